// File: doc/BRIEF.md
# Access Violation Interrupt Collector

This block collects access-violation events from up to four address filter units and turns them into one interrupt line and one bus-response choice. Each filter unit reports two kinds of event on single-cycle pulse inputs: a permission failure, and an overlap error, meaning an access matched two enabled regions. For each filter the block keeps three sticky flags: a pending flag, a repeat flag and an overlap flag.

Software reaches the block through a plain register port with a write strobe, a byte address and combinational read data. It can program a 2-bit action setting, read a packed status word, and write a one-hot clear mask. The action setting sets two things. It chooses whether the pending flags reach the interrupt pin. It also chooses whether failing accesses get an error response or an OKAY response from the fabric.

The flags are recorded whatever the action setting is, so software can poll them even when the interrupt is masked. Matching regions and capturing the failing address are left to the filter units.

Top module: `viol_irq_ctrl`

## Requirements
- R1: After reset, the action setting is 00, every flag is zero, `irq` is low and `resp_decerr` is low.
- R2: A write to offset 0x004 stores wdata[1:0] as the action setting. A read of 0x004 returns it in bits [1:0], with all other bits zero.
- R3: `resp_decerr` equals action bit 0 from the cycle after the write. Codes 01 and 11 select the error response, and 00 and 10 select OKAY.
- R4: `irq` is high exactly when action bit 1 is 1 and at least one pending flag is set. Pending flags are recorded even when action bit 1 is 0.
- R5: A pulse on `fail_pulse[n]` sets pending flag n in the next cycle.
- R6: A pulse on `ovl_pulse[n]` sets both overlap flag n and pending flag n in the next cycle.
- R7: A repeat flag n is set when an event (failure or overlap) reaches filter n while pending flag n is already set. Failure and overlap pulses at the same filter in the same cycle count as one event. Once set, the repeat flag stays set until it is cleared.
- R8: Writing offset 0x014 with bit n of wdata set clears pending, repeat and overlap flag n. Flags of filters whose bit is 0 are kept. A read of 0x014 returns zero.
- R9: If a clear of filter n and an event at filter n fall in the same cycle, the event wins. Pending n becomes 1, repeat n becomes 0, and overlap n becomes 1 only if that event was an overlap.
- R10: A read of offset 0x010 returns pending flags in bits [3:0], repeat flags in bits [11:8] and overlap flags in bits [19:16], indexed by filter. All other bits are zero.
- R11: Filters at or above NUM_FILT read as zero in every field, and clear bits for them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address, used for both reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| fail_pulse | input | NUM_FILT | Per-filter permission-failure pulse |
| ovl_pulse | input | NUM_FILT | Per-filter region-overlap pulse |
| irq | output | 1 | Violation interrupt |
| resp_decerr | output | 1 | 1: return an error response for failing accesses; 0: OKAY |

## Verification
A software clear of a filter and a new violation at that same filter can land on one clock edge. The clear must then give way: the flag stays pending and the repeat history is dropped. The bench provokes this directly, with a clear write in the same cycle as a failure pulse at the cleared filter and at a neighbouring filter. Random runs also issue clear masks and event pulses together at random. After every cycle a bench model, updated from the requirements, predicts the status word, `irq` and `resp_decerr`, and the read port is compared with it.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int MAX_FILT = 4;
  localparam int OFF_W    = 12;
  localparam logic [OFF_W-1:0] OFF_ACTION = 12'h004;
  localparam logic [OFF_W-1:0] OFF_STATUS = 12'h010;
  localparam logic [OFF_W-1:0] OFF_CLEAR  = 12'h014;
  localparam int PEND_LSB = 0;
  localparam int REP_LSB  = 8;
  localparam int OVL_LSB  = 16;
  localparam int FIELD_TOP = OVL_LSB + MAX_FILT;

  typedef enum logic [1:0] {
    ACT_QUIET_OKAY = 2'b00,
    ACT_QUIET_ERR  = 2'b01,
    ACT_IRQ_OKAY   = 2'b10,
    ACT_IRQ_ERR    = 2'b11
  } act_e;
endpackage

// File: rtl/virq_slot.sv
module virq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic ovl_i,
  input  logic clr_i,
  output logic pend_o,
  output logic rep_o,
  output logic ovl_o
);
  logic evt;
  assign evt = fail_i | ovl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      rep_o  <= 1'b0;
      ovl_o  <= 1'b0;
    end else if (clr_i) begin
      // an event in the clearing cycle survives as a first event
      pend_o <= evt;
      rep_o  <= 1'b0;
      ovl_o  <= ovl_i;
    end else if (evt) begin
      pend_o <= 1'b1;
      rep_o  <= rep_o | pend_o;
      ovl_o  <= ovl_o | ovl_i;
    end
  end
endmodule

// File: rtl/virq_action.sv
module virq_action
  import virq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       any_pend_i,
  output act_e       act_o,
  output logic       irq_o,
  output logic       resp_err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_o <= ACT_QUIET_OKAY;
    else if (wr_i) act_o <= act_e'(wdata_i);
  end

  always_comb begin
    unique case (act_o)
      ACT_QUIET_OKAY: begin irq_o = 1'b0;       resp_err_o = 1'b0; end
      ACT_QUIET_ERR:  begin irq_o = 1'b0;       resp_err_o = 1'b1; end
      ACT_IRQ_OKAY:   begin irq_o = any_pend_i; resp_err_o = 1'b0; end
      default:        begin irq_o = any_pend_i; resp_err_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/viol_irq_ctrl.sv
module viol_irq_ctrl
  import virq_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_FILT-1:0] fail_pulse,
  input  logic [NUM_FILT-1:0] ovl_pulse,
  output logic                irq,
  output logic                resp_decerr
);
  localparam int FW = MAX_FILT;

  logic          hit_act, hit_stat, wr_act, wr_clr;
  logic [FW-1:0] clr_mask, evt_all, ovl_in_all;
  logic [FW-1:0] pend_all, rep_all, ovl_all;
  act_e          act_q;

  assign hit_act  = (reg_addr == ADDR_W'(OFF_ACTION));
  assign hit_stat = (reg_addr == ADDR_W'(OFF_STATUS));
  assign wr_act   = reg_wr && hit_act;
  assign wr_clr   = reg_wr && (reg_addr == ADDR_W'(OFF_CLEAR));
  assign clr_mask = wr_clr ? reg_wdata[FW-1:0] : '0;

  for (genvar i = 0; i < FW; i++) begin : g_slot
    if (i < NUM_FILT) begin : g_on
      assign evt_all[i]    = fail_pulse[i] | ovl_pulse[i];
      assign ovl_in_all[i] = ovl_pulse[i];
      virq_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .fail_i (fail_pulse[i]),
        .ovl_i  (ovl_pulse[i]),
        .clr_i  (clr_mask[i]),
        .pend_o (pend_all[i]),
        .rep_o  (rep_all[i]),
        .ovl_o  (ovl_all[i])
      );
    end else begin : g_off
      assign evt_all[i]    = 1'b0;
      assign ovl_in_all[i] = 1'b0;
      assign pend_all[i]   = 1'b0;
      assign rep_all[i]    = 1'b0;
      assign ovl_all[i]    = 1'b0;
    end
  end

  virq_action u_action (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_act),
    .wdata_i    (reg_wdata[1:0]),
    .any_pend_i (|pend_all),
    .act_o      (act_q),
    .irq_o      (irq),
    .resp_err_o (resp_decerr)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_act) begin
      reg_rdata[1:0] = act_q;
    end else if (hit_stat) begin
      reg_rdata[PEND_LSB +: FW] = pend_all;
      reg_rdata[REP_LSB  +: FW] = rep_all;
      reg_rdata[OVL_LSB  +: FW] = ovl_all;
    end
  end
endmodule

// File: rtl/virq_chk.sv
module virq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_act,
  input logic       wr_clr,
  input logic [3:0] wdata_lo,
  input logic [3:0] evt_all,
  input logic [3:0] pend_all,
  input logic [3:0] rep_all,
  input logic [3:0] ovl_all,
  input logic [1:0] act,
  input logic       irq,
  input logic       resp_decerr
);
  AST_RESP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |=> resp_decerr == $past(wdata_lo[0]));  // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |-> !irq);  // R4
  AST_EVENT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_all) |=> (pend_all & $past(evt_all)) == $past(evt_all));  // R5
  AST_OVL_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_all & ~pend_all) == 4'b0);  // R6
  AST_REP_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_all & ~pend_all) == 4'b0);  // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (pend_all & $past(wdata_lo & ~evt_all)) == 4'b0);  // R8
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && |(wdata_lo & evt_all)) |=>
      ((rep_all & $past(wdata_lo & evt_all)) == 4'b0));  // R9
endmodule

bind viol_irq_ctrl virq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_act      (wr_act),
  .wr_clr      (wr_clr),
  .wdata_lo    (reg_wdata[3:0]),
  .evt_all     (evt_all),
  .pend_all    (pend_all),
  .rep_all     (rep_all),
  .ovl_all     (ovl_all),
  .act         (act_q),
  .irq         (irq),
  .resp_decerr (resp_decerr)
);

// File: tb/viol_irq_ctrl_test.sv
`timescale 1ns/1ps
module viol_irq_ctrl_test;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = 12'h000;
  logic [31:0]   reg_wdata = 32'h0;
  logic [31:0]   reg_rdata;
  logic [NF-1:0] fail_pulse = '0;
  logic [NF-1:0] ovl_pulse = '0;
  logic          irq, resp_decerr;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_pend = 4'h0, m_rep = 4'h0, m_ovl = 4'h0;
  logic [1:0] m_act = 2'b00;

  always #2.5 clk = ~clk;

  viol_irq_ctrl #(.NUM_FILT(NF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fail_pulse(fail_pulse),
    .ovl_pulse(ovl_pulse), .irq(irq), .resp_decerr(resp_decerr)
  );

  function automatic logic [31:0] exp_status();
    return {12'h0, m_ovl, 4'h0, m_rep, 4'h0, m_pend};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge(input logic [NF-1:0] f, input logic [NF-1:0] o,
                            input logic wr, input logic [11:0] a, input logic [31:0] d);
    for (int i = 0; i < NF; i++) begin
      logic e;
      e = f[i] | o[i];
      if (wr && a == 12'h014 && d[i]) begin
        m_pend[i] = e; m_rep[i] = 1'b0; m_ovl[i] = o[i];
      end else if (e) begin
        m_rep[i] = m_rep[i] | m_pend[i]; m_pend[i] = 1'b1; m_ovl[i] = m_ovl[i] | o[i];
      end
    end
    if (wr && a == 12'h004) m_act = d[1:0];
  endtask

  task automatic step(input logic [NF-1:0] f, input logic [NF-1:0] o,
                      input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    fail_pulse = f; ovl_pulse = o; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge(f, o, wr, a, d);
    @(negedge clk);
    fail_pulse = '0; ovl_pulse = '0; reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pins_chk(input string req);
    chk({req, " irq"}, {31'h0, irq}, {31'h0, m_act[1] & (|m_pend)});
    chk({req, " resp"}, {31'h0, resp_decerr}, {31'h0, m_act[0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    read_chk("R1 status", 12'h010, 32'h0);
    read_chk("R1 action", 12'h004, 32'h0);
    pins_chk("R1");
    rst_n = 1'b1;

    // R2 action write keeps only two bits
    step('0, '0, 1'b1, 12'h004, 32'hFFFF_FFF1);
    read_chk("R2 action", 12'h004, 32'h1);
    pins_chk("R3 error response");
    step('0, '0, 1'b1, 12'h004, 32'h0);
    pins_chk("R3 okay response");

    // R4 flag recorded with interrupt masked
    step(3'b001, '0, 1'b0, 12'h0, 32'h0);
    read_chk("R5 fail sets pending", 12'h010, 32'h0000_0001);
    chk("R4 masked irq", {31'h0, irq}, 32'h0);
    step('0, '0, 1'b1, 12'h004, 32'h2);
    chk("R4 enabled irq", {31'h0, irq}, 32'h1);

    // R6 overlap
    step('0, 3'b010, 1'b0, 12'h0, 32'h0);
    read_chk("R6 overlap", 12'h010, 32'h0002_0003);
    // R7 repeat
    step(3'b010, '0, 1'b0, 12'h0, 32'h0);
    read_chk("R7 repeat", 12'h010, 32'h0002_0203);
    step(3'b010, 3'b010, 1'b0, 12'h0, 32'h0);
    read_chk("R7 sticky", 12'h010, exp_status());

    // R8 selective clear
    step('0, '0, 1'b1, 12'h014, 32'h2);
    read_chk("R8 clear one", 12'h010, 32'h0000_0001);
    read_chk("R8 clear reads zero", 12'h014, 32'h0);

    // R9 clear and event in the same cycle
    step(3'b001, '0, 1'b0, 12'h0, 32'h0);
    read_chk("R9 setup", 12'h010, 32'h0000_0101);
    step(3'b011, '0, 1'b1, 12'h014, 32'h1);
    read_chk("R9 event wins", 12'h010, 32'h0000_0003);
    step('0, 3'b100, 1'b1, 12'h014, 32'h4);
    read_chk("R9 overlap wins", 12'h010, 32'h0004_0007);
    pins_chk("R9");

    // R11 unimplemented filter
    step(3'b111, '0, 1'b1, 12'h014, 32'h8);
    read_chk("R11 filter3 zero", 12'h010, exp_status());
    chk("R11 bits", reg_rdata & 32'h0008_0808, 32'h0);
    step('0, '0, 1'b1, 12'h014, 32'hF);
    read_chk("R10 all cleared", 12'h010, 32'h0);
    pins_chk("R4 idle");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [NF-1:0] f, o;
      logic wr;
      logic [11:0] a;
      logic [31:0] d;
      f = (($urandom % 4) == 0) ? NF'($urandom) : '0;
      o = (($urandom % 6) == 0) ? NF'($urandom) : '0;
      wr = ($urandom % 3) == 0;
      a = (($urandom % 4) == 0) ? 12'h004 : 12'h014;
      d = $urandom;
      step(f, o, wr, a, d);
      read_chk("R10 random status", 12'h010, exp_status());
      pins_chk("R4 R3 random");
      read_chk("R2 random action", 12'h004, {30'h0, m_act});
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule